// File: doc/BRIEF.md
# Two-Stage Key-Protected Watchdog Timer

This block is a watchdog built from two cascaded up-counters. A prescaler stage counts every clock cycle while the watchdog runs. Each time it wraps, it advances a main stage. The main stage starts from a programmable value, so the time until it overflows can be set. When the main stage overflows, the block sets a sticky overflow flag and emits a one-cycle reset request. It then reloads the main stage with the stored setting and keeps counting.

Software controls the block through a simple 32-bit write bus with three registers. Each register acts only when the top byte of the written word, bits 31..24, carries that register's own key. The registers are: a prescaler-clear register (address 0, key 0x55), a setting register (address 1, key 0x5A) and a flag-clear register (address 2, key 0xA5). A write with any other key is dropped. Both counter values, the run state and the flag are visible as outputs.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, both counters read zero, `running` is 0, `ovf_flag` is 0 and `rst_req` is 0.
- R2: While `running` is 1, `base_cnt` increases by one on every clock edge and wraps from 2^BASE_W-1 to 0.
- R3: A write to address 0 with bits 31..24 equal to 0x55 sets `base_cnt` to 0 on that edge. This clear beats the increment, so the main stage does not advance on that edge even if `base_cnt` was at its maximum.
- R4: `main_cnt` advances by one only on an edge where `base_cnt` wraps.
- R5: A write to address 1 with bits 31..24 equal to 0x5A loads `main_cnt` and the stored setting from bits MAIN_W-1..0, and loads `running` from bit 16 (EN_BIT). The load beats any advance on the same edge.
- R6: Start from `base_cnt`=0 with a setting s written with bit 16 set. The reset request appears exactly (2^MAIN_W - s)*2^BASE_W edges after that write, so s=0 gives the longest timeout.
- R7: On overflow, `rst_req` is 1 for exactly one cycle. On that same edge `main_cnt` reloads with the stored setting and `base_cnt` reads 0.
- R8: `ovf_flag` is set on overflow and stays set until a write to address 2 with bits 31..24 equal to 0xA5. If an overflow and that clear land on the same edge, the flag stays set.
- R9: A write whose bits 31..24 do not match the addressed register's key changes no counter, setting, run state or flag.
- R10: While `running` is 0, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the prescaler stage counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 2 | Register select: 0 prescaler clear, 1 setting, 2 flag clear |
| wr_data | input | 32 | Write word; key in bits 31..24 |
| base_cnt | output | BASE_W | Prescaler stage count |
| main_cnt | output | MAIN_W | Main stage count |
| running | output | 1 | Run state, from bit 16 of the last keyed setting write |
| ovf_flag | output | 1 | Sticky overflow flag |
| rst_req | output | 1 | One-cycle reset request on main overflow |

## Verification
Both counters and the run state are outputs, so a wrong increment, clear priority or enable shows at the ports one edge after it occurs. A corrupted stored setting stays hidden until the next overflow, when the reload value appears on `main_cnt`. That is why every timeout run checks the reload. A lost carry between the stages only shows as a wrong timeout length, so the bench measures the exact edge count for every setting value in a reduced configuration.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int KEY_HI = 31;
    localparam int KEY_LO = 24;

    typedef enum logic [1:0] {
        REG_BASE = 2'd0,
        REG_MAIN = 2'd1,
        REG_FLAG = 2'd2
    } wreg_e;
endpackage

// File: rtl/wdg_wdecode.sv
module wdg_wdecode #(
    parameter int          MAIN_W   = 12,
    parameter int          EN_BIT   = 16,
    parameter logic [7:0]  KEY_BASE = 8'h55,
    parameter logic [7:0]  KEY_MAIN = 8'h5A,
    parameter logic [7:0]  KEY_FLAG = 8'hA5
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              base_clr,
    output logic              main_ld,
    output logic              flag_clr,
    output logic [MAIN_W-1:0] ld_val,
    output logic              ld_en
);
    import wdg_pkg::*;

    localparam int          NREG = 3;
    localparam logic [23:0] KEYS = {KEY_FLAG, KEY_MAIN, KEY_BASE};

    logic [NREG-1:0] hit;
    logic            unused_bits;

    // one key comparator per register
    for (genvar i = 0; i < NREG; i++) begin : g_key
        assign hit[i] = wr_en && (wr_addr == 2'(i))
                        && (wr_data[KEY_HI:KEY_LO] == KEYS[8*i +: 8]);
    end

    assign base_clr    = hit[REG_BASE];
    assign main_ld     = hit[REG_MAIN];
    assign flag_clr    = hit[REG_FLAG];
    assign ld_val      = wr_data[MAIN_W-1:0];
    assign ld_en       = wr_data[EN_BIT];
    assign unused_bits = ^wr_data;
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_q,
    input  logic         step,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    // priority: load, then clear, then step
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q == {W{1'b1}}) begin
                cnt_d = wrap_val;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int          BASE_W   = 18,
    parameter int          MAIN_W   = 12,
    parameter int          EN_BIT   = 16,
    parameter logic [7:0]  KEY_BASE = 8'h55,
    parameter logic [7:0]  KEY_MAIN = 8'h5A,
    parameter logic [7:0]  KEY_FLAG = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [BASE_W-1:0] base_cnt,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              running,
    output logic              ovf_flag,
    output logic              rst_req
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [MAIN_W-1:0] main;
        logic [MAIN_W-1:0] setv;
        logic              en;
        logic              flag;
        logic              req;
    } wdg_state_t;

    wdg_state_t st_q, st_d;

    logic              base_clr, main_ld, flag_clr, ld_en;
    logic [MAIN_W-1:0] ld_val;
    logic [BASE_W-1:0] base_nxt;
    logic [MAIN_W-1:0] main_nxt;
    logic              base_wrap, main_wrap;

    wdg_wdecode #(
        .MAIN_W(MAIN_W), .EN_BIT(EN_BIT),
        .KEY_BASE(KEY_BASE), .KEY_MAIN(KEY_MAIN), .KEY_FLAG(KEY_FLAG)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_clr(base_clr), .main_ld(main_ld), .flag_clr(flag_clr),
        .ld_val(ld_val), .ld_en(ld_en)
    );

    // prescaler stage: wraps to zero, cleared by keyed write
    wdg_stage #(.W(BASE_W)) u_base (
        .cnt_q(st_q.base), .step(st_q.en), .clr(base_clr), .load(1'b0),
        .load_val('0), .wrap_val('0), .cnt_d(base_nxt), .wrap(base_wrap)
    );

    // main stage: steps on prescaler wrap, reloads stored setting on overflow
    wdg_stage #(.W(MAIN_W)) u_main (
        .cnt_q(st_q.main), .step(base_wrap), .clr(1'b0), .load(main_ld),
        .load_val(ld_val), .wrap_val(st_q.setv), .cnt_d(main_nxt), .wrap(main_wrap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.base = base_nxt;
        st_d.main = main_nxt;
        if (main_ld) begin
            st_d.setv = ld_val;
            st_d.en   = ld_en;
        end
        // a new overflow outranks a same-cycle flag clear
        st_d.flag = main_wrap | (st_q.flag & ~flag_clr);
        st_d.req  = main_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_cnt = st_q.base;
    assign main_cnt = st_q.main;
    assign running  = st_q.en;
    assign ovf_flag = st_q.flag;
    assign rst_req  = st_q.req;
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks #(
    parameter int          BASE_W   = 18,
    parameter int          MAIN_W   = 12,
    parameter int          EN_BIT   = 16,
    parameter logic [7:0]  KEY_BASE = 8'h55,
    parameter logic [7:0]  KEY_MAIN = 8'h5A,
    parameter logic [7:0]  KEY_FLAG = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [BASE_W-1:0] base_cnt,
    input logic [MAIN_W-1:0] main_cnt,
    input logic              running,
    input logic              ovf_flag,
    input logic              rst_req
);
    import wdg_pkg::*;

    logic unused_data;
    assign unused_data = ^wr_data;

    logic base_key, main_key, flag_key, main_bad;
    assign base_key = wr_en && wr_addr == REG_BASE && wr_data[KEY_HI:KEY_LO] == KEY_BASE;
    assign main_key = wr_en && wr_addr == REG_MAIN && wr_data[KEY_HI:KEY_LO] == KEY_MAIN;
    assign flag_key = wr_en && wr_addr == REG_FLAG && wr_data[KEY_HI:KEY_LO] == KEY_FLAG;
    assign main_bad = wr_en && wr_addr == REG_MAIN && wr_data[KEY_HI:KEY_LO] != KEY_MAIN;

    p_base_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wr_en) |=> base_cnt == BASE_W'($past(base_cnt) + 1'b1));

    p_base_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        base_key |=> base_cnt == '0);

    p_main_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && base_cnt != {BASE_W{1'b1}}) |=> $stable(main_cnt));

    p_main_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        main_key |=> (main_cnt == $past(wr_data[MAIN_W-1:0]))
                     && (running == $past(wr_data[EN_BIT])));

    p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_req_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ovf_flag);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_key) |=> ovf_flag);

    p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (main_bad && !running) |=> $stable(main_cnt) && !running);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(base_cnt) && $stable(main_cnt));
endmodule

bind keyed_wdog wdog_checks #(
    .BASE_W(BASE_W), .MAIN_W(MAIN_W), .EN_BIT(EN_BIT),
    .KEY_BASE(KEY_BASE), .KEY_MAIN(KEY_MAIN), .KEY_FLAG(KEY_FLAG)
) u_checks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_cnt(base_cnt), .main_cnt(main_cnt), .running(running),
    .ovf_flag(ovf_flag), .rst_req(rst_req)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
    localparam int B = 3;
    localparam int M = 3;
    localparam int BMOD = 1 << B;
    localparam int MMOD = 1 << M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [31:0]  wr_data = 32'd0;
    logic [B-1:0] base_cnt;
    logic [M-1:0] main_cnt;
    logic         running, ovf_flag, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_wdog #(.BASE_W(B), .MAIN_W(M)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_cnt(base_cnt), .main_cnt(main_cnt), .running(running),
        .ovf_flag(ovf_flag), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mset(input logic [7:0] key, input logic en, input int s);
        return {key, 7'd0, en, 16'(s)};
    endfunction

    // called at a negedge; one clock edge elapses; returns at the next negedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = 32'd0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int m0, n, b0, m1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 base", base_cnt, 0);
        check("R1 main", main_cnt, 0);
        check("R1 running", running, 0);
        check("R1 flag", ovf_flag, 0);
        check("R1 req", rst_req, 0);
        idle(3);
        check("R10 base hold after reset", base_cnt, 0);
        check("R10 main hold after reset", main_cnt, 0);

        // R5 load while disabled
        wr(2'd1, mset(8'h5A, 1'b0, 5));
        check("R5 main load", main_cnt, 5);
        check("R5 run bit", running, 0);
        wr(2'd0, 32'h5500_0000);
        check("R3 clear disabled", base_cnt, 0);

        // R2/R4 stepping from zero
        wr(2'd1, mset(8'h5A, 1'b1, 0));
        check("R5 run set", running, 1);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            check("R2 base step", base_cnt, k % BMOD);
            check("R4 main carry", main_cnt, k / BMOD);
        end
        // R3 priority over wrap: base 4 main 2 -> go to base 7
        idle(3);
        check("R2 base at max", base_cnt, BMOD - 1);
        m0 = main_cnt;
        wr(2'd0, 32'h5500_0000);
        check("R3 clear wins", base_cnt, 0);
        check("R3 no main step", main_cnt, m0);
        // R5 priority over carry
        idle(BMOD - 1);
        check("R2 base at max again", base_cnt, BMOD - 1);
        wr(2'd1, mset(8'h5A, 1'b1, 6));
        check("R5 load wins", main_cnt, 6);
        check("R2 base wrapped", base_cnt, 0);

        // R9 wrong keys on prescaler clear while running
        for (int k = 0; k < 256; k++) begin
            if (k == 8'h55) continue;
            b0 = base_cnt;
            wr(2'd0, {8'(k), 24'h0});
            check("R9 base key ignored", base_cnt, (b0 + 1) % BMOD);
        end
        // R9 wrong keys on setting while disabled
        wr(2'd1, mset(8'h5A, 1'b0, 1));
        check("R5 disable", running, 0);
        for (int k = 0; k < 256; k++) begin
            if (k == 8'h5A) continue;
            wr(2'd1, mset(8'(k), 1'b1, 4));
            check("R9 main key ignored", main_cnt, 1);
            check("R9 run unchanged", running, 0);
        end

        // R6/R7 timeout sweep over every setting
        for (int s = 0; s < MMOD; s++) begin
            wr(2'd1, mset(8'h5A, 1'b0, s));
            wr(2'd0, 32'h5500_0000);
            wr(2'd2, 32'hA500_0000);
            check("R8 flag cleared", ovf_flag, 0);
            wr(2'd1, mset(8'h5A, 1'b1, s));
            n = 0;
            while (!rst_req && n < 200) begin
                @(negedge clk);
                n++;
            end
            check("R6 timeout edges", n, BMOD * (MMOD - s));
            check("R7 reload", main_cnt, s);
            check("R7 base zero", base_cnt, 0);
            check("R8 flag set", ovf_flag, 1);
            @(negedge clk);
            check("R7 pulse one cycle", rst_req, 0);
            check("R8 flag sticky", ovf_flag, 1);
        end

        // R9 wrong keys on flag clear
        wr(2'd1, mset(8'h5A, 1'b0, 7));
        for (int k = 0; k < 256; k++) begin
            if (k == 8'hA5) continue;
            wr(2'd2, {8'(k), 24'h0});
            check("R9 flag key ignored", ovf_flag, 1);
        end

        // R8 overflow and clear on the same edge
        wr(2'd0, 32'h5500_0000);
        wr(2'd1, mset(8'h5A, 1'b1, 7));
        idle(BMOD - 1);
        wr(2'd2, 32'hA500_0000);
        check("R8 collision req", rst_req, 1);
        check("R8 collision flag kept", ovf_flag, 1);
        wr(2'd2, 32'hA500_0000);
        check("R8 flag cleared by key", ovf_flag, 0);

        // R10 hold while disabled
        wr(2'd1, mset(8'h5A, 1'b0, 3));
        b0 = base_cnt;
        m1 = main_cnt;
        check("R5 load value", m1, 3);
        idle(5);
        check("R10 base hold", base_cnt, b0);
        check("R10 main hold", main_cnt, m1);

        finish_up();
    end
endmodule